// File: doc/BRIEF.md
# Condition and Flag Unit

This unit sits beside a 16-bit execute stage. When an instruction completes, it turns the operation's result, carry-out and signed-overflow indication into five arithmetic status flags: zero, sign, odd parity, carry and overflow. It then decides whether those flags reach the stored flags register. It also decides, before the instruction commits, whether the instruction's condition holds, by testing the stored flags against a 4-bit condition code.

The instruction supplies a 3-bit condition field. An extend prefix, seen earlier in the byte stream, lifts that field into the upper eight codes, which cover the signed and parity tests. A separate toggle prefix inverts the default rule for whether flags are written: unconditional instructions write flags and conditional ones do not. Both prefix indicators are held inside the unit and are consumed by the next completing instruction. The execute stage supplies a per-operation write mask, so that each operation class updates only the flags it defines. A sixth bit, the MMU-off flag, shares the register but is driven only by a fault controller.

Top module: `cond_flag_unit`

## Requirements
- R1: After synchronous reset, all six bits of `flags_q` are 0 and both prefix indicators are clear. With field 6 and no new prefix, `cond_true` is then 1.
- R2: When a write happens, the new zero flag (bit 0) is 1 exactly when `op_result` is 0. The sign flag (bit 1) copies the result's top bit. The parity flag (bit 2) is 1 when the result has an odd number of one bits.
- R3: When a write happens, the carry flag (bit 3) takes `op_carry` and the overflow flag (bit 4) takes `op_ovf`.
- R4: With the extend indicator clear, fields 0 to 5 give `cond_true` = Z, !Z, C&!Z, !C|Z, !C and C.
- R5: With the extend indicator clear, fields 6 and 7 give `cond_true` = 1 whatever the flags hold.
- R6: With the extend indicator set, the effective code is field+8. Codes 8 to 15 give S, !S, !Z&(S==V), Z|(S!=V), S!=V, S==V, P and !P.
- R7: With no toggle prefix, `flag_we` is 1 on a completing instruction exactly when its effective code is 6 or 7. Otherwise `flags_q` bits 4..0 hold. `flag_we` is 0 whenever `exec_valid` is 0.
- R8: A toggle prefix inverts the R7 decision for the next completing instruction only.
- R9: When `cond_true` is 0, `flag_we` is 0 and the flags are unchanged, whatever the prefixes are.
- R10: On a write, only the flag bits whose `wr_mask` bit is 1 change. Mask bits sit at the same positions as the flags: Z=0, S=1, P=2, C=3, V=4.
- R11: Both prefix indicators clear on the clock edge where `exec_valid` is 1. A prefix strobe on that same edge wins and applies to the following instruction.
- R12: Bit 5 of `flags_q` (MMU-off) is set by `mf_set` and cleared by `mf_clr`, and set wins if both are high. Instruction flag writes never change it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pfx_ext | input | 1 | Extend-condition prefix seen (one-cycle strobe) |
| pfx_tgl | input | 1 | Toggle-flags prefix seen (one-cycle strobe) |
| exec_valid | input | 1 | An instruction completes this cycle |
| cond_field | input | 3 | Condition field of the instruction |
| wr_mask | input | 5 | Flags this operation may write (Z,S,P,C,V at bits 0..4) |
| op_result | input | DATA_W | Operation result |
| op_carry | input | 1 | Carry-out of the operation |
| op_ovf | input | 1 | Signed overflow of the operation |
| mf_set | input | 1 | Fault controller sets the MMU-off flag |
| mf_clr | input | 1 | Fault controller clears the MMU-off flag |
| cond_true | output | 1 | Condition of the current instruction holds |
| flag_we | output | 1 | Flags are written at this edge |
| flags_q | output | 6 | Stored flags: Z,S,P,C,V,MMU-off at bits 0..5 |

## Verification
The bench preloads every reachable combination of the five flags, and a zero result cannot carry a set sign or parity flag. For each combination it walks all 32 mixes of extend, toggle and condition field, checking `cond_true`, `flag_we` and the stored flags. This catches a mistaken condition equation, such as a swapped signed test or a parity sense inverted. It also catches code 6 being treated as conditional, or 14 and 15 being treated as unconditional, and a write that slips through on a false condition. A sweep over all 32 write masks would expose a masked bit that leaks or a wanted bit that sticks. Back-to-back instructions after a prefix show whether an indicator lingers past its instruction. The MMU-off checks show whether an instruction write clobbers the fault controller's bit.

// File: rtl/cfu_pkg.sv
package cfu_pkg;

    localparam int ARITH_FLAGS = 5;
    localparam int ALL_FLAGS   = 6;
    localparam int CODE_W      = 4;

    typedef struct packed {
        logic ovf;
        logic carry;
        logic par;
        logic neg;
        logic zero;
    } arith_flags_t;

    typedef struct packed {
        logic         mmu_off;
        arith_flags_t ar;
    } flag_reg_t;

    localparam logic [ARITH_FLAGS-1:0] MASK_ADDSUB = 5'b11111;
    localparam logic [ARITH_FLAGS-1:0] MASK_SHR    = 5'b01111;
    localparam logic [ARITH_FLAGS-1:0] MASK_LOGIC  = 5'b00111;

    function automatic logic is_uncond(input logic [CODE_W-1:0] code);
        return (code == 4'd6) || (code == 4'd7);
    endfunction

endpackage

// File: rtl/cfu_flag_gen.sv
module cfu_flag_gen
    import cfu_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic [DATA_W-1:0] result,
    input  logic              carry,
    input  logic              ovf,
    output arith_flags_t      flags
);
    localparam int MSB = DATA_W - 1;

    always_comb begin
        flags.zero  = ~|result;
        flags.neg   = result[MSB];
        flags.par   = ^result;
        flags.carry = carry;
        flags.ovf   = ovf;
    end
endmodule

// File: rtl/cfu_cond_eval.sv
module cfu_cond_eval
    import cfu_pkg::*;
(
    input  logic [CODE_W-1:0] code,
    input  arith_flags_t      flags,
    output logic              hold
);
    logic sv_eq;

    always_comb begin
        sv_eq = (flags.neg == flags.ovf);
        unique case (code)
            4'd0:  hold = flags.zero;
            4'd1:  hold = !flags.zero;
            4'd2:  hold = flags.carry && !flags.zero;
            4'd3:  hold = !flags.carry || flags.zero;
            4'd4:  hold = !flags.carry;
            4'd5:  hold = flags.carry;
            4'd6:  hold = 1'b1;
            4'd7:  hold = 1'b1;
            4'd8:  hold = flags.neg;
            4'd9:  hold = !flags.neg;
            4'd10: hold = !flags.zero && sv_eq;
            4'd11: hold = flags.zero || !sv_eq;
            4'd12: hold = !sv_eq;
            4'd13: hold = sv_eq;
            4'd14: hold = flags.par;
            default: hold = !flags.par;
        endcase
    end
endmodule

// File: rtl/cfu_prefix_reg.sv
module cfu_prefix_reg (
    input  logic clk,
    input  logic rst,
    input  logic consume,
    input  logic set_ext,
    input  logic set_tgl,
    output logic ext_q,
    output logic tgl_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            ext_q <= 1'b0;
            tgl_q <= 1'b0;
        end else begin
            if (consume) begin
                ext_q <= 1'b0;
                tgl_q <= 1'b0;
            end
            if (set_ext) ext_q <= 1'b1;
            if (set_tgl) tgl_q <= 1'b1;
        end
    end
endmodule

// File: rtl/cond_flag_unit.sv
module cond_flag_unit
    import cfu_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   pfx_ext,
    input  logic                   pfx_tgl,
    input  logic                   exec_valid,
    input  logic [2:0]             cond_field,
    input  logic [ARITH_FLAGS-1:0] wr_mask,
    input  logic [DATA_W-1:0]      op_result,
    input  logic                   op_carry,
    input  logic                   op_ovf,
    input  logic                   mf_set,
    input  logic                   mf_clr,
    output logic                   cond_true,
    output logic                   flag_we,
    output logic [ALL_FLAGS-1:0]   flags_q
);
    logic              ext_q;
    logic              tgl_q;
    logic [CODE_W-1:0] eff_code;
    logic              default_we;
    arith_flags_t      new_flags;
    flag_reg_t         freg;

    cfu_prefix_reg u_pfx (
        .clk     (clk),
        .rst     (rst),
        .consume (exec_valid),
        .set_ext (pfx_ext),
        .set_tgl (pfx_tgl),
        .ext_q   (ext_q),
        .tgl_q   (tgl_q)
    );

    assign eff_code = {ext_q, cond_field};

    cfu_cond_eval u_cond (
        .code  (eff_code),
        .flags (freg.ar),
        .hold  (cond_true)
    );

    cfu_flag_gen #(.DATA_W(DATA_W)) u_gen (
        .result (op_result),
        .carry  (op_carry),
        .ovf    (op_ovf),
        .flags  (new_flags)
    );

    assign default_we = is_uncond(eff_code);
    assign flag_we    = exec_valid && cond_true && (default_we ^ tgl_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            freg <= '0;
        end else begin
            if (flag_we)
                freg.ar <= (freg.ar & ~wr_mask) | (new_flags & wr_mask);
            if (mf_set)
                freg.mmu_off <= 1'b1;
            else if (mf_clr)
                freg.mmu_off <= 1'b0;
        end
    end

    assign flags_q = freg;
endmodule

// File: rtl/cond_flag_unit_chk.sv
module cond_flag_unit_chk #(
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              exec_valid,
    input logic              pfx_ext,
    input logic              pfx_tgl,
    input logic              cond_true,
    input logic              flag_we,
    input logic [4:0]        wr_mask,
    input logic [DATA_W-1:0] op_result,
    input logic [5:0]        flags_q,
    input logic              mf_set,
    input logic              ext_q,
    input logic              tgl_q
);
    assert_reset_clear_R1: assert property (@(posedge clk)
        rst |=> (flags_q == 6'd0 && !ext_q && !tgl_q));

    assert_zero_flag_R2: assert property (@(posedge clk) disable iff (rst)
        (flag_we && wr_mask[0]) |=> (flags_q[0] == ($past(op_result) == '0)));

    assert_idle_hold_R7: assert property (@(posedge clk) disable iff (rst)
        !flag_we |=> $stable(flags_q[4:0]));

    assert_no_exec_no_write_R7: assert property (@(posedge clk) disable iff (rst)
        !exec_valid |-> !flag_we);

    assert_false_cond_no_write_R9: assert property (@(posedge clk) disable iff (rst)
        !cond_true |-> !flag_we);

    assert_unmasked_keep_R10: assert property (@(posedge clk) disable iff (rst)
        flag_we |=> (((flags_q[4:0] ^ $past(flags_q[4:0])) & ~$past(wr_mask)) == 5'd0));

    assert_ext_consumed_R11: assert property (@(posedge clk) disable iff (rst)
        (exec_valid && !pfx_ext) |=> !ext_q);

    assert_tgl_consumed_R11: assert property (@(posedge clk) disable iff (rst)
        (exec_valid && !pfx_tgl) |=> !tgl_q);

    assert_mf_set_R12: assert property (@(posedge clk) disable iff (rst)
        mf_set |=> flags_q[5]);
endmodule

bind cond_flag_unit cond_flag_unit_chk #(.DATA_W(DATA_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .exec_valid (exec_valid),
    .pfx_ext    (pfx_ext),
    .pfx_tgl    (pfx_tgl),
    .cond_true  (cond_true),
    .flag_we    (flag_we),
    .wr_mask    (wr_mask),
    .op_result  (op_result),
    .flags_q    (flags_q),
    .mf_set     (mf_set),
    .ext_q      (ext_q),
    .tgl_q      (tgl_q)
);

// File: tb/test_cond_flag_unit.sv
module test_cond_flag_unit;
    localparam int CLK_PERIOD = 10;
    localparam int DW = 16;

    logic          clk = 1'b0;
    logic          rst;
    logic          pfx_ext, pfx_tgl, exec_valid;
    logic [2:0]    cond_field;
    logic [4:0]    wr_mask;
    logic [DW-1:0] op_result;
    logic          op_carry, op_ovf, mf_set, mf_clr;
    logic          cond_true, flag_we;
    logic [5:0]    flags_q;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cond_flag_unit #(.DATA_W(DW)) i_cond_flag_unit (
        .clk(clk), .rst(rst), .pfx_ext(pfx_ext), .pfx_tgl(pfx_tgl),
        .exec_valid(exec_valid), .cond_field(cond_field), .wr_mask(wr_mask),
        .op_result(op_result), .op_carry(op_carry), .op_ovf(op_ovf),
        .mf_set(mf_set), .mf_clr(mf_clr), .cond_true(cond_true),
        .flag_we(flag_we), .flags_q(flags_q)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [4:0] calc_flags(input logic [DW-1:0] r, input logic c, input logic v);
        logic z, s, p;
        z = (r == 0);
        s = r[DW-1];
        p = ($countones(r) % 2) == 1;
        return {v, c, p, s, z};
    endfunction

    function automatic logic exp_cond(input int code, input logic [4:0] f);
        logic z, s, p, c, v;
        {v, c, p, s, z} = f;
        case (code)
            0: return z;
            1: return !z;
            2: return c && !z;
            3: return !c || z;
            4: return !c;
            5: return c;
            6, 7: return 1'b1;
            8: return s;
            9: return !s;
            10: return !z && (s == v);
            11: return z || (s != v);
            12: return s != v;
            13: return s == v;
            14: return p;
            default: return !p;
        endcase
    endfunction

    // called just after a negedge; returns the combinational outputs seen before the edge
    task automatic do_exec(input logic [2:0] cc, input logic [4:0] m, input logic [DW-1:0] r,
                           input logic c, input logic v, output logic ct, output logic we);
        cond_field = cc; wr_mask = m; op_result = r; op_carry = c; op_ovf = v;
        exec_valid = 1'b1;
        #1;
        ct = cond_true;
        we = flag_we;
        @(posedge clk);
        @(negedge clk);
        exec_valid = 1'b0;
    endtask

    task automatic do_prefix(input logic x, input logic t);
        if (x || t) begin
            pfx_ext = x; pfx_tgl = t;
            @(posedge clk);
            @(negedge clk);
            pfx_ext = 1'b0; pfx_tgl = 1'b0;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [DW-1:0] loads [5];
        logic ct, we;
        logic [4:0] base, nxt, expf;
        int code;
        string tag;

        loads[0] = 16'h0000; loads[1] = 16'h0001; loads[2] = 16'h0003;
        loads[3] = 16'h8000; loads[4] = 16'h8001;

        rst = 1'b1; pfx_ext = 0; pfx_tgl = 0; exec_valid = 0; cond_field = 3'd6;
        wr_mask = 0; op_result = 0; op_carry = 0; op_ovf = 0; mf_set = 0; mf_clr = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        check("R1 flags after reset", flags_q, 6'd0);
        check("R1 field 6 unextended after reset", cond_true, 1'b1);

        // exhaustive sweep over reachable flag states, prefixes and fields
        nxt = calc_flags(16'h0003, 1'b1, 1'b1);
        for (int li = 0; li < 5; li++) begin
            for (int cv = 0; cv < 4; cv++) begin
                base = calc_flags(loads[li], cv[1], cv[0]);
                for (int k = 0; k < 32; k++) begin
                    logic x, t;
                    logic [2:0] cc;
                    logic ec, ew;
                    x = k[4]; t = k[3]; cc = k[2:0];
                    do_exec(3'd7, 5'b11111, loads[li], cv[1], cv[0], ct, we);
                    if (k == 0) begin
                        check("R2 zero/sign/parity load", {27'd0, flags_q[2:0]}, {27'd0, base[2:0]});
                        check("R3 carry/overflow load", {30'd0, flags_q[4:3]}, {30'd0, base[4:3]});
                    end
                    do_prefix(x, t);
                    code = {28'd0, x, cc};
                    ec = exp_cond(code, base);
                    ew = ec && ((!x && cc >= 3'd6) ^ t);
                    do_exec(cc, 5'b11111, 16'h0003, 1'b1, 1'b1, ct, we);
                    if (x) tag = "R6 extended condition";
                    else if (cc >= 3'd6) tag = "R5 unconditional field";
                    else tag = "R4 base condition";
                    check(tag, ct, ec);
                    if (!ec) tag = "R9 false condition blocks write";
                    else if (t) tag = "R8 toggle inverts write rule";
                    else tag = "R7 default write rule";
                    check(tag, we, ew);
                    check(tag, {27'd0, flags_q[4:0]}, {27'd0, ew ? nxt : base});
                end
            end
        end

        // write-mask sweep
        for (int m = 0; m < 32; m++) begin
            base = calc_flags(16'h8001, 1'b0, 1'b0);
            do_exec(3'd7, 5'b11111, 16'h8001, 1'b0, 1'b0, ct, we);
            do_exec(3'd7, m[4:0], 16'h0000, 1'b1, 1'b1, ct, we);
            nxt = calc_flags(16'h0000, 1'b1, 1'b1);
            expf = (base & ~m[4:0]) | (nxt & m[4:0]);
            check("R10 masked write", {27'd0, flags_q[4:0]}, {27'd0, expf});
        end

        // prefix consumed by one instruction only
        do_exec(3'd7, 5'b11111, 16'h0001, 1'b0, 1'b0, ct, we); // parity odd
        do_prefix(1'b1, 1'b1);
        do_exec(3'd7, 5'b11111, 16'h0003, 1'b0, 1'b0, ct, we); // code 15 false
        check("R11 extended field 7 is even parity", ct, 1'b0);
        do_exec(3'd6, 5'b11111, 16'h0003, 1'b0, 1'b0, ct, we);
        check("R11 indicators cleared after instruction", {30'd0, ct, we}, 32'd3);
        // prefix strobe coinciding with exec applies to the next one
        pfx_ext = 1'b1;
        do_exec(3'd7, 5'b00000, 16'h0003, 1'b0, 1'b0, ct, we);
        pfx_ext = 1'b0;
        check("R11 same-edge prefix ignored by current", ct, 1'b1);
        do_exec(3'd6, 5'b00000, 16'h0003, 1'b0, 1'b0, ct, we); // code 14, P=0
        check("R11 same-edge prefix kept for next", ct, 1'b0);

        // MMU-off flag
        mf_set = 1'b1; @(posedge clk); @(negedge clk); mf_set = 1'b0;
        check("R12 mmu-off set", flags_q[5], 1'b1);
        do_exec(3'd7, 5'b11111, 16'h0000, 1'b0, 1'b0, ct, we);
        check("R12 instruction write keeps mmu-off", flags_q[5], 1'b1);
        mf_clr = 1'b1; @(posedge clk); @(negedge clk); mf_clr = 1'b0;
        check("R12 mmu-off clear", flags_q[5], 1'b0);
        mf_set = 1'b1; mf_clr = 1'b1; @(posedge clk); @(negedge clk);
        mf_set = 1'b0; mf_clr = 1'b0;
        check("R12 set wins over clear", flags_q[5], 1'b1);

        // reset again clears everything
        do_prefix(1'b1, 1'b0);
        rst = 1'b1; @(posedge clk); @(negedge clk); rst = 1'b0;
        cond_field = 3'd6; #1;
        check("R1 reset clears flags", flags_q, 6'd0);
        check("R1 reset clears extend indicator", cond_true, 1'b1);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule